// File: doc/BRIEF.md
# Wake Pattern Match Engine

This block watches received Ethernet frames, one 32-bit dword per cycle, and decides whether a frame carries one of up to eight wake-up patterns. The patterns sit in a 64-word by 40-bit pattern store that the host fills while matching is switched off. Word 0 holds an enable bit for each pattern and the start addresses of patterns 0 to 3. Word 1 holds the start addresses of patterns 4 to 7. Every other word holds a control byte and four pattern bytes. The control byte carries an end-of-pattern flag, a skip count of 0 to 7 frame dwords, and a four-bit byte mask.

Each of the eight pattern lanes keeps its own word pointer and skip counter and moves forward on every received dword. A lane that sees a mismatch drops out for the rest of the frame. When the frame ends, any lane that has already matched its last word sets a sticky match flag and a power-management status bit. The wake event output is driven from that status bit, gated by an event enable and an override enable.

The frame controller has two states, `FR_IDLE` and `FR_RECV`. A start of frame with matching on moves it from `FR_IDLE` to `FR_RECV`. An end of frame moves it back to `FR_IDLE`, and so does switching matching off. A start of frame while in `FR_RECV` restarts the frame. Each lane has four states, `LN_IDLE`, `LN_RUN`, `LN_HIT` and `LN_MISS`. A start of frame moves an enabled lane to `LN_RUN` and a disabled lane to `LN_IDLE`. From `LN_RUN`, a passing compare of a word marked last moves to `LN_HIT`. A failing compare, or a passing compare of non-last word 63, moves to `LN_MISS`. An end of frame, or matching being switched off, returns the lane to `LN_IDLE`.

Top module: `wpm_engine`

## Requirements
- R1: While `mode_en` is 0, a host write stores `host_wdata` at `host_waddr`. `host_rdata` shows the word at `host_raddr` one clock after the address is presented.
- R2: While `mode_en` is 1, host writes have no effect and `host_rdata` reads as all zeros one clock later.
- R3: Bits 7:0 of word 0 enable patterns 0 to 7, with bit n enabling pattern n. The start address of pattern p, taken from the low 6 bits of its byte, is in byte p+1 of word 0 for p from 0 to 3 and in byte p-3 of word 1 for p from 4 to 7. Byte k occupies bits 8k+7:8k.
- R4: In a pattern word, bit 7 marks the last word, bits 6:4 hold the skip count and bits 3:0 hold the mask. Pattern byte n (bits 8n+15:8n+8) is compared with bits 8n+7:8n of the frame dword.
- R5: Before a pattern word is compared, as many frame dwords as its skip count are consumed without a compare.
- R6: A mask bit of 0 takes the matching byte out of the compare. A mask of 3 compares only pattern bytes 0 and 1.
- R7: A mismatch drops that pattern for the rest of the frame, and the other patterns carry on independently.
- R8: A frame matches only if some enabled pattern has matched its last word by end of frame. A pattern that is still incomplete at end of frame does not match, and a pattern that runs past word 63 without a last mark fails.
- R9: A matching frame sets `match_flag` and `pm_status` in the clock after `rx_eof`. Both are sticky, both are cleared by `clr_match` and `clr_pm` respectively, a set in the same cycle wins over a clear, and reset clears both.
- R10: `pm_event` is high exactly when `pm_status` is 1 and either `evt_en` or `evt_ovr` is 1.
- R11: While `mode_en` is 0 no frame is matched. Dropping `mode_en` during a frame discards that frame.
- R12: The pattern store keeps its contents across `rst_n`.
- R13: Dwords outside a frame are ignored. A start of frame during a frame restarts matching from the first dword that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_en | input | 1 | Pattern-match mode enable |
| host_we | input | 1 | Pattern store write strobe |
| host_waddr | input | 6 | Pattern store write address |
| host_wdata | input | 40 | Pattern store write data |
| host_raddr | input | 6 | Pattern store read address |
| host_rdata | output | 40 | Pattern store read data, registered |
| rx_sof | input | 1 | Start-of-frame marker (carries no data) |
| rx_dw_valid | input | 1 | Received dword valid |
| rx_dw | input | 32 | Received dword, first byte in bits 7:0 |
| rx_eof | input | 1 | End-of-frame marker |
| clr_match | input | 1 | Clears the match flag |
| clr_pm | input | 1 | Clears the power-management status |
| evt_en | input | 1 | Wake event enable |
| evt_ovr | input | 1 | Wake event override enable |
| match_flag | output | 1 | Sticky pattern-match flag |
| pm_status | output | 1 | Sticky power-management status |
| pm_event | output | 1 | Wake event output |

## Verification
Frames are built so that one changed dword decides the result. A frame that differs only in a masked-in byte must miss, while the same frame with a change in a masked-out byte must still hit. This separates mask handling from whole-word compares. A pattern with a skip count of two is given frames with the target dword at position 2 and with the frame too short to reach it. The first must hit, the second must not, which separates skipping from plain sequential matching and shows that an incomplete pattern is not counted. Further frames cover one lane failing while another hits, enables and word-1 pointers being rewritten, a start of frame repeated mid-frame, dwords arriving before a frame starts, and matching being switched off mid-frame.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

    localparam int WPM_WORD_W = 40;
    localparam int WPM_ADDR_W = 6;
    localparam int WPM_NPAT   = 8;
    localparam int WPM_DW_W   = 32;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_RUN,
        LN_HIT,
        LN_MISS
    } lane_st_t;

    typedef enum logic {
        FR_IDLE,
        FR_RECV
    } frame_st_t;

    // control byte of a pattern word: [7] last, [6:4] skip, [3:0] mask
    typedef struct packed {
        logic       last;
        logic [2:0] skip;
        logic [3:0] mask;
    } pat_ctrl_t;

    function automatic pat_ctrl_t ctrl_of(input logic [WPM_WORD_W-1:0] w);
        return pat_ctrl_t'(w[7:0]);
    endfunction

endpackage

// File: rtl/wpm_pattern_mem.sv
module wpm_pattern_mem #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 40,
    parameter int NPAT   = 8
) (
    input  logic                          clk,
    input  logic                          lock,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [WORD_W-1:0]             rd_data,
    input  logic [NPAT-1:0][ADDR_W-1:0]   lane_addr,
    output logic [NPAT-1:0][WORD_W-1:0]   lane_word,
    output logic [WORD_W-1:0]             word0,
    output logic [WORD_W-1:0]             word1
);
    localparam int DEPTH = 1 << ADDR_W;

    // no reset: contents persist across every reset
    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && !lock) begin
            store[wr_addr] <= wr_data;
        end
        rd_data <= lock ? '0 : store[rd_addr];
    end

    assign word0 = store[0];
    assign word1 = store[1];

    for (genvar p = 0; p < NPAT; p++) begin : g_port
        assign lane_word[p] = store[lane_addr[p]];
    end

endmodule

// File: rtl/wpm_lane.sv
module wpm_lane
    import wpm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 40,
    parameter int DW_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              enable,
    input  logic              clear,
    input  logic              dw_go,
    input  logic [DW_W-1:0]   dw_data,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic [WORD_W-1:0] entry,
    output logic [ADDR_W-1:0] ptr,
    output logic              hit_now
);
    localparam int NBYTE = DW_W / 8;
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    lane_st_t    st_q, st_d;
    logic [ADDR_W-1:0] ptr_d;
    logic [2:0]  skip_q, skip_d;
    pat_ctrl_t   ctl;
    logic [NBYTE-1:0] byte_ok;
    logic        word_ok;
    logic        skipping;

    assign ctl      = ctrl_of(entry);
    assign skipping = (skip_q < ctl.skip);

    always_comb begin
        for (int n = 0; n < NBYTE; n++) begin
            byte_ok[n] = !ctl.mask[n] ||
                         (dw_data[8*n +: 8] == entry[8*(n+1) +: 8]);
        end
        word_ok = &byte_ok;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= LN_IDLE;
            ptr    <= '0;
            skip_q <= '0;
        end else begin
            st_q   <= st_d;
            ptr    <= ptr_d;
            skip_q <= skip_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d    = st_q;
        ptr_d   = ptr;
        skip_d  = skip_q;
        hit_now = (st_q == LN_HIT);
        if (start) begin
            st_d   = enable ? LN_RUN : LN_IDLE;
            ptr_d  = start_ptr;
            skip_d = '0;
        end else begin
            unique case (st_q)
                LN_IDLE: ;
                LN_RUN: begin
                    if (dw_go) begin
                        if (skipping) begin
                            skip_d = skip_q + 3'd1;
                        end else if (!word_ok) begin
                            st_d = LN_MISS;
                        end else if (ctl.last) begin
                            st_d    = LN_HIT;
                            hit_now = 1'b1;
                        end else if (ptr == LAST_ADDR) begin
                            st_d = LN_MISS;
                        end else begin
                            ptr_d  = ptr + 1'b1;
                            skip_d = '0;
                        end
                    end
                end
                LN_HIT:  ;
                LN_MISS: ;
                default: st_d = LN_IDLE;
            endcase
            if (clear) begin
                st_d = LN_IDLE;
            end
        end
    end

endmodule

// File: rtl/wpm_frame_ctl.sv
module wpm_frame_ctl
    import wpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic rx_sof,
    input  logic rx_eof,
    input  logic rx_dw_valid,
    input  logic any_hit,
    input  logic clr_match,
    input  logic clr_pm,
    output logic lane_start,
    output logic lane_clear,
    output logic dw_go,
    output logic match_flag,
    output logic pm_status
);
    frame_st_t st_q, st_d;
    logic match_set;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= FR_IDLE;
            match_flag <= 1'b0;
            pm_status  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (match_set)      match_flag <= 1'b1;
            else if (clr_match) match_flag <= 1'b0;
            if (match_set)      pm_status <= 1'b1;
            else if (clr_pm)    pm_status <= 1'b0;
        end
    end

    // next state and outputs
    always_comb begin
        st_d       = st_q;
        lane_start = mode_en && rx_sof;
        lane_clear = !mode_en || rx_eof;
        dw_go      = 1'b0;
        match_set  = 1'b0;
        unique case (st_q)
            FR_IDLE: begin
                if (mode_en && rx_sof) st_d = FR_RECV;
            end
            FR_RECV: begin
                if (!mode_en) begin
                    st_d = FR_IDLE;
                end else if (rx_sof) begin
                    st_d = FR_RECV;
                end else begin
                    dw_go = rx_dw_valid;
                    if (rx_eof) begin
                        st_d      = FR_IDLE;
                        match_set = any_hit;
                    end
                end
            end
            default: st_d = FR_IDLE;
        endcase
    end

endmodule

// File: rtl/wpm_engine.sv
module wpm_engine
    import wpm_pkg::*;
#(
    parameter int ADDR_W = WPM_ADDR_W,
    parameter int WORD_W = WPM_WORD_W,
    parameter int NPAT   = WPM_NPAT,
    parameter int DW_W   = WPM_DW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_waddr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [ADDR_W-1:0] host_raddr,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              rx_sof,
    input  logic              rx_dw_valid,
    input  logic [DW_W-1:0]   rx_dw,
    input  logic              rx_eof,
    input  logic              clr_match,
    input  logic              clr_pm,
    input  logic              evt_en,
    input  logic              evt_ovr,
    output logic              match_flag,
    output logic              pm_status,
    output logic              pm_event
);
    localparam int PTRS_W0 = NPAT / 2;

    logic [NPAT-1:0][ADDR_W-1:0] lane_ptr;
    logic [NPAT-1:0][WORD_W-1:0] lane_word;
    logic [WORD_W-1:0] word0, word1;
    logic [NPAT-1:0]   lane_hit;
    logic lane_start, lane_clear, dw_go;

    wpm_pattern_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NPAT(NPAT)) u_mem (
        .clk       (clk),
        .lock      (mode_en),
        .wr_en     (host_we),
        .wr_addr   (host_waddr),
        .wr_data   (host_wdata),
        .rd_addr   (host_raddr),
        .rd_data   (host_rdata),
        .lane_addr (lane_ptr),
        .lane_word (lane_word),
        .word0     (word0),
        .word1     (word1)
    );

    for (genvar p = 0; p < NPAT; p++) begin : g_lane
        logic [ADDR_W-1:0] sptr;
        if (p < PTRS_W0) begin : g_w0
            assign sptr = word0[8*(p+1) +: ADDR_W];
        end else begin : g_w1
            assign sptr = word1[8*(p-PTRS_W0+1) +: ADDR_W];
        end

        wpm_lane #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DW_W(DW_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (lane_start),
            .enable    (word0[p]),
            .clear     (lane_clear),
            .dw_go     (dw_go),
            .dw_data   (rx_dw),
            .start_ptr (sptr),
            .entry     (lane_word[p]),
            .ptr       (lane_ptr[p]),
            .hit_now   (lane_hit[p])
        );
    end

    wpm_frame_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_en     (mode_en),
        .rx_sof      (rx_sof),
        .rx_eof      (rx_eof),
        .rx_dw_valid (rx_dw_valid),
        .any_hit     (|lane_hit),
        .clr_match   (clr_match),
        .clr_pm      (clr_pm),
        .lane_start  (lane_start),
        .lane_clear  (lane_clear),
        .dw_go       (dw_go),
        .match_flag  (match_flag),
        .pm_status   (pm_status)
    );

    assign pm_event = pm_status && (evt_en || evt_ovr);

endmodule

// File: rtl/wpm_engine_chk.sv
module wpm_engine_chk #(
    parameter int WORD_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_en,
    input logic              rx_eof,
    input logic              clr_match,
    input logic              match_flag,
    input logic              pm_status,
    input logic              pm_event,
    input logic [WORD_W-1:0] host_rdata
);
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !clr_match) |=> match_flag);

    a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && clr_match && !rx_eof) |=> !match_flag);

    a_r8_set_only_at_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_flag && !rx_eof) |=> !match_flag);

    a_r11_mode_off_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_flag && !mode_en) |=> !match_flag);

    a_r10_event_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        pm_event |-> pm_status);

    a_r2_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mode_en |=> (host_rdata == '0));

endmodule

bind wpm_engine wpm_engine_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_en    (mode_en),
    .rx_eof     (rx_eof),
    .clr_match  (clr_match),
    .match_flag (match_flag),
    .pm_status  (pm_status),
    .pm_event   (pm_event),
    .host_rdata (host_rdata)
);

// File: tb/wpm_engine_bench.sv
`timescale 1ns/1ps
module wpm_engine_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_en = 1'b0, host_we = 1'b0;
    logic [5:0] host_waddr = '0, host_raddr = '0;
    logic [39:0] host_wdata = '0, host_rdata;
    logic rx_sof = 1'b0, rx_dw_valid = 1'b0, rx_eof = 1'b0;
    logic [31:0] rx_dw = '0;
    logic clr_match = 1'b0, clr_pm = 1'b0, evt_en = 1'b0, evt_ovr = 1'b0;
    logic match_flag, pm_status, pm_event;

    int checks = 0, fails = 0;
    logic [31:0] fq[$];

    always #10 clk = ~clk;

    wpm_engine u_wpm_engine (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .rx_sof(rx_sof), .rx_dw_valid(rx_dw_valid), .rx_dw(rx_dw), .rx_eof(rx_eof),
        .clr_match(clr_match), .clr_pm(clr_pm), .evt_en(evt_en), .evt_ovr(evt_ovr),
        .match_flag(match_flag), .pm_status(pm_status), .pm_event(pm_event)
    );

    // ---------------- behavioural reference model ----------------
    logic [39:0] mm [64];
    logic [31:0] mq[$];
    bit in_frame = 0;
    logic exp_match = 1'b0, exp_pm = 1'b0;
    logic [39:0] exp_rdata;

    function automatic bit model_eval();
        for (int p = 0; p < 8; p++) begin
            int ptr, idx;
            if (mm[0][p] !== 1'b1) continue;
            ptr = (p < 4) ? int'(mm[0][8*(p+1) +: 6]) : int'(mm[1][8*(p-3) +: 6]);
            idx = 0;
            for (int step = 0; step < 64; step++) begin
                logic [39:0] w;
                bit ok;
                w = mm[ptr];
                idx += int'(w[6:4]);
                if (idx >= mq.size()) break;
                ok = 1;
                for (int n = 0; n < 4; n++)
                    if (w[n] && mq[idx][8*n +: 8] !== w[8*(n+1) +: 8]) ok = 0;
                if (!ok) break;
                idx++;
                if (w[7]) return 1;
                if (ptr == 63) break;
                ptr++;
            end
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        exp_rdata <= mode_en ? 40'd0 : mm[host_raddr];
        if (host_we && !mode_en) mm[host_waddr] <= host_wdata;
        if (!rst_n) begin
            exp_match <= 1'b0;
            exp_pm    <= 1'b0;
            in_frame  = 0;
        end else begin
            bit set;
            set = 0;
            if (!mode_en) begin
                in_frame = 0;
            end else if (rx_sof) begin
                in_frame = 1;
                mq.delete();
            end else if (in_frame) begin
                if (rx_dw_valid) mq.push_back(rx_dw);
                if (rx_eof) begin
                    set = model_eval();
                    in_frame = 0;
                end
            end
            exp_match <= set ? 1'b1 : (clr_match ? 1'b0 : exp_match);
            exp_pm    <= set ? 1'b1 : (clr_pm ? 1'b0 : exp_pm);
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model, away from the edges
    always begin
        @(posedge clk);
        #5;
        if (rst_n) begin
            chk("R9 match_flag vs model", 64'(match_flag), 64'(exp_match));
            chk("R9 pm_status vs model", 64'(pm_status), 64'(exp_pm));
            chk("R10 pm_event vs model", 64'(pm_event),
                64'(exp_pm && (evt_en || evt_ovr)));
            if (!$isunknown(exp_rdata))
                chk("R1 host_rdata vs model", 64'(host_rdata), 64'(exp_rdata));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [5:0] a, input logic [39:0] d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [39:0] d);
        @(negedge clk);
        host_raddr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic send_frame(input bit clr_with_eof);
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0;
        foreach (fq[i]) begin
            rx_dw_valid = 1'b1; rx_dw = fq[i];
            @(negedge clk);
        end
        rx_dw_valid = 1'b0;
        rx_eof = 1'b1; clr_match = clr_with_eof;
        @(negedge clk);
        rx_eof = 1'b0; clr_match = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk); clr_match = 1'b1; clr_pm = 1'b1;
        @(negedge clk); clr_match = 1'b0; clr_pm = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk); mode_en = m;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        logic [39:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset match_flag", 64'(match_flag), 64'd0);
        chk("R9 reset pm_status", 64'(pm_status), 64'd0);

        // load patterns: p0 @2, p1 @4, p5 @4 via word 1
        wr(6'd0, 40'h0A_06_04_02_03);
        wr(6'd1, 40'h0C_0C_04_0C_00);
        wr(6'd2, 40'hDD_CC_BB_AA_0F);
        wr(6'd3, 40'h00_00_22_11_93);
        wr(6'd4, 40'h04_03_02_01_AF);
        rd(6'd3, rv);
        chk("R1 readback word3", 64'(rv), 64'h00_00_22_11_93);

        set_mode(1'b1);
        // R4 R5 R6: word layout, skip of one, mask 3 ignores upper bytes
        fq = '{32'hDDCCBBAA, 32'h0, 32'h55662211};
        send_frame(0);
        chk("R4 R6 frame A match", 64'(match_flag), 64'd1);
        chk("R10 event off without enables", 64'(pm_event), 64'd0);
        @(negedge clk); evt_ovr = 1'b1; #1;
        chk("R10 event via override", 64'(pm_event), 64'd1);
        @(negedge clk); evt_ovr = 1'b0; evt_en = 1'b1; #1;
        chk("R10 event via enable", 64'(pm_event), 64'd1);
        clear_flags();
        chk("R9 cleared by host", 64'(match_flag), 64'd0);

        // R6: masked-in byte differs
        fq = '{32'hDDCCBBAA, 32'h0, 32'h55662311};
        send_frame(0);
        chk("R6 masked-in mismatch", 64'(match_flag), 64'd0);

        // R5: skip of two reaches third dword
        fq = '{32'h0, 32'h0, 32'h04030201};
        send_frame(0);
        chk("R5 skip two match", 64'(match_flag), 64'd1);
        clear_flags();

        // R8: frame ends before the skipped-to dword
        fq = '{32'h04030201};
        send_frame(0);
        chk("R8 incomplete no match", 64'(match_flag), 64'd0);

        // R7: p0 fails, p1 still hits
        fq = '{32'hDDCCBBAA, 32'h0, 32'h04030201};
        send_frame(0);
        chk("R7 independent lanes", 64'(match_flag), 64'd1);
        clear_flags();

        // R3: disable p1, then enable p5 whose pointer sits in word 1
        set_mode(1'b0);
        wr(6'd0, 40'h0A_06_04_02_01);
        set_mode(1'b1);
        fq = '{32'h0, 32'h0, 32'h04030201};
        send_frame(0);
        chk("R3 disabled pattern", 64'(match_flag), 64'd0);
        set_mode(1'b0);
        wr(6'd0, 40'h0A_06_04_02_21);
        set_mode(1'b1);
        send_frame(0);
        chk("R3 word1 pointer", 64'(match_flag), 64'd1);

        // R9: set wins over a clear in the same cycle
        fq = '{32'hDDCCBBAA, 32'h0, 32'h55662211};
        send_frame(1);
        chk("R9 set beats clear", 64'(match_flag), 64'd1);
        clear_flags();

        // R13: dword before sof is ignored
        @(negedge clk); rx_dw_valid = 1'b1; rx_dw = 32'hDDCCBBAA;
        @(negedge clk); rx_dw_valid = 1'b0;
        fq = '{32'h0, 32'h55662211};
        send_frame(0);
        chk("R13 pre-frame dword ignored", 64'(match_flag), 64'd0);
        // R13: repeated sof restarts the frame
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0; rx_dw_valid = 1'b1; rx_dw = 32'h12345678;
        @(negedge clk); rx_dw_valid = 1'b0;
        fq = '{32'hDDCCBBAA, 32'h0, 32'h55662211};
        send_frame(0);
        chk("R13 sof restart", 64'(match_flag), 64'd1);
        clear_flags();

        // R11: mode off, and mode dropped mid-frame
        set_mode(1'b0);
        send_frame(0);
        chk("R11 mode off no match", 64'(match_flag), 64'd0);
        set_mode(1'b1);
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0; rx_dw_valid = 1'b1; rx_dw = 32'hDDCCBBAA;
        @(negedge clk); rx_dw = 32'h0;
        @(negedge clk); rx_dw_valid = 1'b0; mode_en = 1'b0;
        @(negedge clk); mode_en = 1'b1; rx_dw_valid = 1'b1; rx_dw = 32'h55662211;
        @(negedge clk); rx_dw_valid = 1'b0; rx_eof = 1'b1;
        @(negedge clk); rx_eof = 1'b0;
        @(negedge clk);
        chk("R11 mid-frame drop", 64'(match_flag), 64'd0);

        // R2: locked writes ignored, locked reads zero
        wr(6'd2, 40'h0);
        rd(6'd2, rv);
        chk("R2 locked read zero", 64'(rv), 64'd0);
        set_mode(1'b0);
        rd(6'd2, rv);
        chk("R2 locked write ignored", 64'(rv), 64'hDD_CC_BB_AA_0F);

        // R12: contents survive reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(6'd4, rv);
        chk("R12 store kept over reset", 64'(rv), 64'h04_03_02_01_AF);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule